// File: doc/BRIEF.md
# Descriptor-Driven Infrared Carrier Sequencer

This block produces an infrared transmit waveform from a list of segment descriptors held in word-addressed memory. After a start command it reads a 32-bit byte-length header from the base address, then fetches 16-bit descriptors one at a time. Each descriptor says whether the carrier is gated on, which of two carrier timing sets (normal or alternate) to use, and how many carrier periods the segment lasts. The carrier itself is a PWM pulse: within each period the output is high for the first `compare` clock ticks and low for the rest.

The next descriptor is prefetched while the current segment plays, so consecutive segments abut. When the last segment ends, a sticky done flag is raised, the block returns to idle and the output stays low. To send more, software must write a new list and issue a new start. The done flag is cleared by a write-one pulse, and it drives an interrupt line through an enable.

The controller has five states. IDLE waits for `start`. HDR_LO reads the low header word. HDR_HI reads the high header word and latches the low word. HDR_CHK assembles the length: a zero or odd length takes the `bad_header` transition back to IDLE and raises done; otherwise the `arm` transition goes to RUN. RUN fetches and plays descriptors and takes the `list_end` transition to IDLE, raising done. IDLE goes to HDR_LO on `start_seen`, and the two header states each step forward unconditionally.

Top module: `irwave_seq`

## Requirements
- R1: The header is read as two words: the low 16 bits from `base_addr` and the high 16 bits from `base_addr`+1, on the first and second cycles after `start` is sampled. Descriptors follow from `base_addr`+2 in increasing address order, and their count is the header byte length divided by two.
- R2: Descriptor bit 15 gates the carrier (1 = on). Bit 14 picks the timing set (0 = `norm_period`/`norm_cmp`, 1 = `alt_period`/`alt_cmp`). Bits 13:0 give the segment length in carrier periods of that set.
- R3: While the carrier is on, each period lasts `period` ticks, with `pwm_out` high for the first `cmp` ticks. A `cmp` of 0 gives all low, and a `cmp` at or above `period` gives all high. Periods must be at least 2.
- R4: A segment with the carrier off keeps `pwm_out` low for its whole duration.
- R5: The first segment's first output cycle is the seventh clock cycle after the edge that samples `start`. Each later segment starts in the cycle right after the previous one ends, with no gap.
- R6: A descriptor with length 0 adds no output time, as long as the segment playing while it is fetched lasts at least two cycles per such descriptor plus two. A list made only of such descriptors raises done with `pwm_out` never high.
- R7: In the cycle after the last output cycle, `done` is 1, `busy` is 0 and `pwm_out` is 0. While idle, no reads are issued and `pwm_out` stays low.
- R8: A header length of zero or an odd value reads no descriptors and produces no output. `done` is 1 and `busy` is 0 in the fourth cycle after `start` is sampled.
- R9: `done` stays set until a cycle with `done_clr` = 1, after which it reads 0. A set event in the same cycle wins over a clear.
- R10: `irq` equals `done` when `irq_en` is 1 and is 0 otherwise.
- R11: `start` is ignored while `busy` is 1, and the waveform in progress is unaffected.
- R12: A new `start` after done replays the list from `base_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin transmission (sampled only in IDLE) |
| base_addr | input | ADDR_W | Word address of the header |
| norm_period | input | TICK_W | Normal set carrier period in ticks |
| norm_cmp | input | TICK_W | Normal set high ticks per period |
| alt_period | input | TICK_W | Alternate set carrier period in ticks |
| alt_cmp | input | TICK_W | Alternate set high ticks per period |
| irq_en | input | 1 | Interrupt enable |
| done_clr | input | 1 | Write-one clear of the done flag |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory word address |
| rd_data | input | 16 | Read data, valid the cycle after `rd_en` |
| pwm_out | output | 1 | Modulated IR output |
| busy | output | 1 | High while not in IDLE |
| done | output | 1 | Sticky list-finished flag |
| irq | output | 1 | `done` gated by `irq_en` |

## Verification
The bench builds the block with ADDR_W = 8 and TICK_W = 6. This small configuration lets it sweep every normal period from 2 to 4 against every compare value from 0 to one past the period, with the alternate set running at a complementary duty. That covers the all-low, partial and all-high carrier cases in both timing sets, in lists that switch sets and the carrier gate between every segment. Short periods place two-cycle segments back to back, which exercises the no-gap prefetch at its limit. Lists that mix in zero-length descriptors check that they are skipped without adding time. Runs with an empty header, an odd header and an all-zero list cover the other ways a list can end.

// File: rtl/irw_pkg.sv
package irw_pkg;

    localparam int DESC_W   = 16;
    localparam int SEGLEN_W = 14;
    localparam int HDR_W    = 32;
    localparam int COUNT_W  = HDR_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR_LO,
        ST_HDR_HI,
        ST_HDR_CHK,
        ST_RUN
    } seq_state_e;

    // Field positions are part of the in-memory format.
    typedef struct packed {
        logic                carrier_on;
        logic                alt_set;
        logic [SEGLEN_W-1:0] periods;
    } seg_desc_t;

endpackage

// File: rtl/irw_fetch.sv
module irw_fetch
    import irw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               arm,
    input  logic [ADDR_W-1:0]  arm_addr,
    input  logic [COUNT_W-1:0] arm_count,
    input  logic               take,
    input  logic [DESC_W-1:0]  rd_data,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic               buf_valid,
    output seg_desc_t          buf_desc,
    output logic               drained
);

    logic [COUNT_W-1:0] left_q;
    logic [ADDR_W-1:0]  ptr_q;
    logic               pend_q;
    seg_desc_t          resp_desc;
    logic               resp_keep;

    // Issue a read when nothing is in flight, words remain and the
    // single prefetch slot is empty or being emptied this cycle.
    assign rd_en     = enable && !pend_q && (left_q != '0) && (!buf_valid || take);
    assign rd_addr   = ptr_q;
    assign drained   = (left_q == '0) && !pend_q;
    assign resp_desc = seg_desc_t'(rd_data);
    assign resp_keep = pend_q && (resp_desc.periods != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q    <= '0;
            ptr_q     <= '0;
            pend_q    <= 1'b0;
            buf_valid <= 1'b0;
            buf_desc  <= '0;
        end else begin
            if (arm) begin
                ptr_q  <= arm_addr;
                left_q <= arm_count;
            end else if (rd_en) begin
                ptr_q  <= ptr_q + ADDR_W'(1);
                left_q <= left_q - COUNT_W'(1);
            end
            pend_q <= rd_en;
            if (take) begin
                buf_valid <= 1'b0;
            end
            // Zero-length descriptors are dropped on arrival.
            if (resp_keep) begin
                buf_valid <= 1'b1;
                buf_desc  <= resp_desc;
            end
        end
    end

endmodule

// File: rtl/irw_carrier.sv
module irw_carrier
    import irw_pkg::*;
#(
    parameter int TICK_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                ld_on,
    input  logic [TICK_W-1:0]   ld_period,
    input  logic [TICK_W-1:0]   ld_cmp,
    input  logic [SEGLEN_W-1:0] ld_len,
    output logic                active,
    output logic                last_tick,
    output logic                carrier_on,
    output logic                pwm
);

    logic [TICK_W-1:0]   tick_q;
    logic [TICK_W-1:0]   per_q;
    logic [TICK_W-1:0]   cmp_q;
    logic [SEGLEN_W-1:0] rem_q;
    logic                on_q;
    logic                act_q;
    logic                period_end;

    assign period_end = (tick_q == per_q - TICK_W'(1));
    assign last_tick  = act_q && period_end && (rem_q == SEGLEN_W'(1));
    assign active     = act_q;
    assign carrier_on = on_q;
    assign pwm        = act_q && on_q && (tick_q < cmp_q);

    // Timing values are captured at segment load so that register
    // updates never disturb a segment already in play.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            per_q  <= '0;
            cmp_q  <= '0;
            rem_q  <= '0;
            on_q   <= 1'b0;
            act_q  <= 1'b0;
        end else if (load) begin
            act_q  <= 1'b1;
            on_q   <= ld_on;
            per_q  <= ld_period;
            cmp_q  <= ld_cmp;
            rem_q  <= ld_len;
            tick_q <= '0;
        end else if (act_q) begin
            if (period_end) begin
                tick_q <= '0;
                if (rem_q == SEGLEN_W'(1)) begin
                    act_q <= 1'b0;
                end
                rem_q <= rem_q - SEGLEN_W'(1);
            end else begin
                tick_q <= tick_q + TICK_W'(1);
            end
        end
    end

endmodule

// File: rtl/irw_done_flag.sv
module irw_done_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    output logic done,
    output logic irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (set) begin
            done <= 1'b1;
        end else if (clr) begin
            done <= 1'b0;
        end
    end

    assign irq = done && irq_en;

endmodule

// File: rtl/irwave_seq.sv
module irwave_seq
    import irw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [TICK_W-1:0] norm_period,
    input  logic [TICK_W-1:0] norm_cmp,
    input  logic [TICK_W-1:0] alt_period,
    input  logic [TICK_W-1:0] alt_cmp,
    input  logic              irq_en,
    input  logic              done_clr,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DESC_W-1:0] rd_data,
    output logic              pwm_out,
    output logic              busy,
    output logic              done,
    output logic              irq
);

    localparam int HALF_W = HDR_W / 2;

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] base_q;
    logic [HALF_W-1:0] hdr_lo_q;
    logic [HDR_W-1:0]  hdr_len;
    logic              hdr_bad;

    logic              hdr_rd;
    logic [ADDR_W-1:0] hdr_addr;
    logic              fetch_en;
    logic              arm;
    logic              raise_done;

    logic              f_rd_en;
    logic [ADDR_W-1:0] f_rd_addr;
    logic              buf_valid;
    seg_desc_t         buf_desc;
    logic              drained;

    logic              seg_active;
    logic              seg_last;
    logic              seg_on;
    logic              seg_load;
    logic              list_end;
    logic [TICK_W-1:0] sel_period;
    logic [TICK_W-1:0] sel_cmp;

    assign hdr_len  = {rd_data, hdr_lo_q};
    assign hdr_bad  = (hdr_len == '0) || hdr_len[0];
    assign seg_load = (state_q == ST_RUN) && buf_valid && (!seg_active || seg_last);
    assign list_end = (!seg_active || seg_last) && !buf_valid && drained;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Header capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            hdr_lo_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                base_q <= base_addr;
            end
            if (state_q == ST_HDR_HI) begin
                hdr_lo_q <= rd_data;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_HDR_LO;
            ST_HDR_LO:  state_d = ST_HDR_HI;
            ST_HDR_HI:  state_d = ST_HDR_CHK;
            ST_HDR_CHK: state_d = hdr_bad ? ST_IDLE : ST_RUN;
            ST_RUN:     if (list_end) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        hdr_rd     = 1'b0;
        hdr_addr   = base_q;
        fetch_en   = 1'b0;
        arm        = 1'b0;
        raise_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_HDR_LO: begin
                hdr_rd   = 1'b1;
                hdr_addr = base_q;
            end
            ST_HDR_HI: begin
                hdr_rd   = 1'b1;
                hdr_addr = base_q + ADDR_W'(1);
            end
            ST_HDR_CHK: begin
                if (hdr_bad) begin
                    raise_done = 1'b1;
                end else begin
                    arm = 1'b1;
                end
            end
            ST_RUN: begin
                fetch_en   = 1'b1;
                raise_done = list_end;
            end
            default: begin
            end
        endcase
    end

    assign rd_en      = hdr_rd || f_rd_en;
    assign rd_addr    = hdr_rd ? hdr_addr : f_rd_addr;
    assign busy       = (state_q != ST_IDLE);
    assign sel_period = buf_desc.alt_set ? alt_period : norm_period;
    assign sel_cmp    = buf_desc.alt_set ? alt_cmp    : norm_cmp;

    irw_fetch #(
        .ADDR_W(ADDR_W)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (fetch_en),
        .arm       (arm),
        .arm_addr  (base_q + ADDR_W'(2)),
        .arm_count (hdr_len[HDR_W-1:1]),
        .take      (seg_load),
        .rd_data   (rd_data),
        .rd_en     (f_rd_en),
        .rd_addr   (f_rd_addr),
        .buf_valid (buf_valid),
        .buf_desc  (buf_desc),
        .drained   (drained)
    );

    irw_carrier #(
        .TICK_W(TICK_W)
    ) u_play (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (seg_load),
        .ld_on      (buf_desc.carrier_on),
        .ld_period  (sel_period),
        .ld_cmp     (sel_cmp),
        .ld_len     (buf_desc.periods),
        .active     (seg_active),
        .last_tick  (seg_last),
        .carrier_on (seg_on),
        .pwm        (pwm_out)
    );

    irw_done_flag u_done (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (raise_done),
        .clr    (done_clr),
        .irq_en (irq_en),
        .done   (done),
        .irq    (irq)
    );

endmodule

// File: rtl/irwave_seq_chk.sv
module irwave_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic done_clr,
    input logic rd_en,
    input logic pwm_out,
    input logic seg_active,
    input logic seg_on
);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_en && !pwm_out));

    // R7
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr) |=> done);

    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !busy) |=> !done);

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || $rose(done)));

    // R4
    carrier_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_active && !seg_on) |-> !pwm_out);

endmodule

bind irwave_seq irwave_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .done_clr   (done_clr),
    .rd_en      (rd_en),
    .pwm_out    (pwm_out),
    .seg_active (seg_active),
    .seg_on     (seg_on)
);

// File: tb/irwave_seq_tb.sv
module irwave_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int TW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [TW-1:0] norm_period = TW'(2);
    logic [TW-1:0] norm_cmp = '0;
    logic [TW-1:0] alt_period = TW'(2);
    logic [TW-1:0] alt_cmp = '0;
    logic          irq_en = 1'b0;
    logic          done_clr = 1'b0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [15:0]   rd_data;
    logic          pwm_out, busy, done, irq;

    logic [15:0] mem [0:255];
    logic [15:0] dl  [0:15];
    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end

    irwave_seq #(.ADDR_W(AW), .TICK_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .norm_period(norm_period), .norm_cmp(norm_cmp),
        .alt_period(alt_period), .alt_cmp(alt_cmp),
        .irq_en(irq_en), .done_clr(done_clr),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out), .busy(busy), .done(done), .irq(irq)
    );

    function automatic logic [15:0] mk(input bit on, input bit alt, input int len);
        return {on, alt, 14'(len)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_done();
        @(negedge clk) done_clr = 1'b1;
        @(negedge clk) done_clr = 1'b0;
    endtask

    task automatic issue_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // Plays dl[0..n-1] from base; poke_at injects start at that output
    // cycle index (-2 = last cycle, -1 = never).
    task automatic play(input int base, input int n, input int poke_at, input string req);
        bit exp_q[$];
        int hdr;
        int bad_k;
        int bad_act;
        int poke;
        hdr = 2 * n;
        mem[base]   = hdr[15:0];
        mem[base+1] = hdr[31:16];
        for (int i = 0; i < n; i++) mem[base+2+i] = dl[i];
        for (int i = 0; i < n; i++) begin
            int p, c, len;
            bit on;
            on  = dl[i][15];
            p   = dl[i][14] ? int'(alt_period) : int'(norm_period);
            c   = dl[i][14] ? int'(alt_cmp)    : int'(norm_cmp);
            len = int'(dl[i][13:0]);
            for (int q = 0; q < len; q++)
                for (int t = 0; t < p; t++) exp_q.push_back(on && (t < c));
        end
        poke = (poke_at == -2) ? exp_q.size() - 1 : poke_at;
        clear_done();
        base_addr = AW'(base);
        issue_start();
        repeat (6) @(negedge clk);
        bad_k = -1;
        bad_act = 0;
        for (int k = 0; k < exp_q.size(); k++) begin
            start = (k == poke);
            if (bad_k < 0 && (pwm_out !== exp_q[k] || busy !== 1'b1)) begin
                bad_k = k;
                bad_act = pwm_out;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(bad_k < 0, req, "waveform mismatch at cycle (actual=index)", bad_k, -1);
        if (bad_k >= 0) $display("  pwm at that cycle %0d", bad_act);
        chk(done === 1'b1 && busy === 1'b0 && pwm_out === 1'b0, "R7",
            "done/busy/pwm after last segment", {done, busy, pwm_out}, 3'b100);
    endtask

    task automatic bad_header(input int base, input int lo, input int hi);
        mem[base]   = 16'(lo);
        mem[base+1] = 16'(hi);
        clear_done();
        base_addr = AW'(base);
        issue_start();
        chk(rd_en === 1'b1 && rd_addr === AW'(base), "R1", "header low read addr",
            int'(rd_addr), base);
        @(negedge clk);
        chk(rd_en === 1'b1 && rd_addr === AW'(base + 1), "R1", "header high read addr",
            int'(rd_addr), base + 1);
        @(negedge clk);
        @(negedge clk);
        chk(done === 1'b1 && busy === 1'b0, "R8", "done after bad header",
            {done, busy}, 2'b10);
        begin
            int seen = 0;
            for (int k = 0; k < 6; k++) begin
                if (rd_en !== 1'b0 || pwm_out !== 1'b0) seen++;
                @(negedge clk);
            end
            chk(seen == 0, "R8", "reads/pulses after bad header", seen, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(pwm_out === 1'b0 && busy === 1'b0 && done === 1'b0 && irq === 1'b0 && rd_en === 1'b0,
            "R7", "reset outputs", {pwm_out, busy, done, irq, rd_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 sweep over both timing sets and all duty corners
        for (int np = 2; np <= 4; np++) begin
            for (int nc = 0; nc <= np + 1; nc++) begin
                norm_period = TW'(np);
                norm_cmp    = TW'(nc);
                alt_period  = TW'(np + 1);
                alt_cmp     = TW'(np + 1 - nc);
                dl[0] = mk(1, 0, 2);
                dl[1] = mk(0, 0, 1);
                dl[2] = mk(1, 1, 2);
                dl[3] = mk(0, 1, 1);
                dl[4] = mk(1, 0, 1);
                play(16 + np, 5, (np == 2 && nc == 1) ? 3 : -1, "R3");
            end
        end

        // R11 start on the final output cycle; R6 zero-length descriptors
        norm_period = TW'(4); norm_cmp = TW'(1);
        alt_period  = TW'(5); alt_cmp  = TW'(3);
        dl[0] = mk(1, 0, 3);
        dl[1] = mk(1, 1, 0);
        dl[2] = mk(0, 0, 0);
        dl[3] = mk(0, 1, 2);
        dl[4] = mk(1, 0, 2);
        dl[5] = mk(1, 1, 0);
        play(40, 6, -2, "R6");

        // R12 replay the same list again from the same base
        play(40, 6, -1, "R12");

        // R10 interrupt gating
        irq_en = 1'b0;
        @(negedge clk);
        chk(irq === 1'b0 && done === 1'b1, "R10", "irq masked while done", irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq === 1'b1, "R10", "irq enabled while done", irq, 1);

        // R9 sticky done and write-one clear
        repeat (4) @(negedge clk);
        chk(done === 1'b1, "R9", "done holds without clear", done, 1);
        clear_done();
        chk(done === 1'b0 && irq === 1'b0, "R9", "done cleared", done, 0);
        irq_en = 1'b0;

        // R8 empty and odd headers
        bad_header(80, 0, 0);
        bad_header(90, 5, 0);

        // R6 list made only of zero-length descriptors
        dl[0] = mk(1, 0, 0);
        dl[1] = mk(0, 1, 0);
        dl[2] = mk(1, 1, 0);
        mem[100] = 16'd6; mem[101] = 16'd0;
        for (int i = 0; i < 3; i++) mem[102+i] = dl[i];
        clear_done();
        base_addr = AW'(100);
        issue_start();
        begin
            int hi_seen = 0;
            int waited = 0;
            while (done !== 1'b1 && waited < 40) begin
                if (pwm_out !== 1'b0) hi_seen++;
                waited++;
                @(negedge clk);
            end
            chk(done === 1'b1 && busy === 1'b0, "R6", "all-zero list finishes", done, 1);
            chk(hi_seen == 0, "R6", "no pulse for all-zero list", hi_seen, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule